// File: doc/BRIEF.md
# Handshaked Command Packet Transmitter

This block sends one short command packet from a host to a peripheral controller over a byte-wide serial transmitter. The packet may be one to eight bytes long. The host first writes the payload into a small indexed buffer and then issues a send request with the packet length. The block asserts a request-to-send line and waits for clear-to-send from the far side. It then offers each payload byte in index order to a byte sink, and the sink stands in for the UART shifter. It offers a byte only after the sink reports that both its holding stage and its shifter are empty. After the last payload byte it appends a checksum byte.

The checksum is the XOR of all payload bytes. When bit 7 of that XOR is set, the value is further XORed with 0xC0, so the checksum byte always has bit 7 clear. Two typical packets are a display contrast command of three bytes (0x83, 0x43, value) and a backlight command of five bytes (0x85, 0x41, 0x02, value, 0x02). After the checksum byte has fully drained, the block holds request-to-send for a guard time of 1.5 ms, derived from the clock-frequency parameter. It then releases the line and pulses a done output.

A request that arrives while request-to-send is high, or that carries an illegal length, is refused with a one-cycle busy pulse, and nothing else happens. If clear-to-send does not arrive within a parameterised number of cycles, the transfer is abandoned: request-to-send drops and an error pulse is raised.

Top module: `cmd_pkt_tx`

## Requirements
- R1: After synchronous reset, rts, tx_valid, done, busy_nack and cts_err are all low.
- R2: In the cycle after a send_req with send_len between 1 and MAX_BYTES is sampled while rts is low, rts is high. Payload byte k is the last value written through load_we with load_idx = k.
- R3: A send_req sampled while rts is high produces busy_nack high for exactly the following cycle. It leaves the transfer in progress and the bytes it sends unchanged.
- R4: A send_req with send_len equal to 0 or greater than MAX_BYTES, sampled while rts is low, produces a one-cycle busy_nack, and rts stays low.
- R5: No byte is offered on tx_valid before cts has been seen high for the current packet. Payload bytes leave in index order 0, 1, ..., send_len-1.
- R6: tx_valid rises only in the cycle after tx_empty was high. While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data is held.
- R7: Exactly send_len+1 bytes are sent. The last byte is the XOR of the payload bytes, further XORed with 0xC0 when its bit 7 is 1.
- R8: Let N = ceil(CLK_HZ*3/2000). rts falls N+1 cycles after the first cycle in which tx_empty is sampled high after the checksum byte was accepted.
- R9: done is high for exactly one cycle, the first cycle with rts low after a completed packet. It never rises together with cts_err.
- R10: If cts stays low, rts falls and cts_err pulses for one cycle at the edge CTS_TIMEOUT+1 cycles after the accepting edge. No byte is sent and done stays low.
- R11: Payload buffer writes (load_we) while rts is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Write strobe for the payload buffer |
| load_idx | input | $clog2(MAX_BYTES) | Payload byte index to write |
| load_data | input | 8 | Payload byte value |
| send_req | input | 1 | Request to send the buffered packet |
| send_len | input | $clog2(MAX_BYTES+1) | Payload length for the request |
| busy_nack | output | 1 | One-cycle refusal pulse |
| rts | output | 1 | Request-to-send line |
| cts | input | 1 | Clear-to-send from the far side |
| tx_valid | output | 1 | Byte offered to the sink |
| tx_data | output | 8 | Byte value offered |
| tx_ready | input | 1 | Sink accepts the offered byte |
| tx_empty | input | 1 | Sink holding stage and shifter both empty |
| done | output | 1 | One-cycle pulse after rts release on success |
| cts_err | output | 1 | One-cycle pulse on clear-to-send timeout |

## Verification
The busy refusal is registered, so busy_nack is checked in the cycle that immediately follows the sampled request. Bytes are recorded at the edge where tx_valid and tx_ready are both high, and the checksum position and value are compared after done. The guard interval is checked as an exact edge count: with a sink drain time of D cycles, the release edge comes D+N+2 edges after the checksum acceptance edge. The timeout is checked the same way, with the release edge at CTS_TIMEOUT+1 edges after the accepting edge. All outputs are sampled on the falling clock edge, and inputs change just after it, so each count lands on a known cycle.

// File: rtl/cmd_pkt_tx_pkg.sv
package cmd_pkt_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CTS,
        ST_DRAIN,
        ST_SEND,
        ST_GUARD
    } tx_state_e;

    // Applied to the running XOR when its top bit is set
    localparam logic [7:0] FOLD_MASK = 8'hC0;

    typedef struct packed {
        logic load;
        logic run;
    } tmr_ctl_t;

    function automatic logic [7:0] chk_fold(input logic [7:0] acc);
        return acc[7] ? (acc ^ FOLD_MASK) : acc;
    endfunction

    // Cycles in 1.5 ms, rounded up
    function automatic int unsigned guard_cycles(input int unsigned hz);
        return (hz * 3 + 1999) / 2000;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cpt_payload_buf.sv
module cpt_payload_buf #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int RD_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [RD_W-1:0]  rd_idx,
    output logic [7:0]       rd_data
);

    logic [DEPTH-1:0][7:0] slot;
    logic [DEPTH-1:0]      hit;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_dec
            assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) slot[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_idx < RD_W'(DEPTH)) rd_data = slot[rd_idx[IDX_W-1:0]];
    end

    // R11: contents change only through an enabled write
    p_hold_without_write_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(slot));

endmodule

// File: rtl/cpt_checksum.sv
module cpt_checksum (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       add,
    input  logic [7:0] din,
    output logic [7:0] chk_out
);
    import cmd_pkt_tx_pkg::*;

    logic [7:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= 8'h00;
        else if (add)     acc <= acc ^ din;
    end

    assign chk_out = chk_fold(acc);

    // R7: folding always leaves the top bit clear
    p_chk_top_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !chk_out[7]);

endmodule

// File: rtl/cpt_timer.sv
module cpt_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (run && cnt != '0)  cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    // R8/R10: a running count steps down by one and never wraps
    p_step_down_r8: assert property (@(posedge clk) disable iff (rst)
        (run && !load && !expired) |=> (cnt == $past(cnt) - W'(1)));
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);

endmodule

// File: rtl/cmd_pkt_tx.sv
module cmd_pkt_tx #(
    parameter int MAX_BYTES   = 8,
    parameter int CLK_HZ      = 50_000_000,
    parameter int CTS_TIMEOUT = 100_000,
    localparam int IDX_W      = $clog2(MAX_BYTES),
    localparam int LEN_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_we,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [7:0]       load_data,
    input  logic             send_req,
    input  logic [LEN_W-1:0] send_len,
    output logic             busy_nack,
    output logic             rts,
    input  logic             cts,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    input  logic             tx_empty,
    output logic             done,
    output logic             cts_err
);
    import cmd_pkt_tx_pkg::*;

    localparam int unsigned GUARD_N = guard_cycles(CLK_HZ);
    localparam int unsigned TMR_MAX = max_u(GUARD_N, CTS_TIMEOUT);
    localparam int          TMR_W   = $clog2(TMR_MAX + 1);
    localparam int          POS_W   = $clog2(MAX_BYTES + 2);

    tx_state_e        state;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] len_q;
    logic [7:0]       buf_rd;
    logic [7:0]       chk;
    logic             len_ok;
    logic             accept;
    logic             last_drained;
    logic             payload_phase;
    tmr_ctl_t         tctl;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_exp;

    assign len_ok        = (send_len != '0) && (send_len <= LEN_W'(MAX_BYTES));
    assign accept        = (state == ST_IDLE) && send_req && len_ok;
    assign last_drained  = (state == ST_DRAIN) && tx_empty && (pos > len_q);
    assign payload_phase = (pos < len_q);

    always_comb begin
        tctl.load = accept || last_drained;
        tctl.run  = (state == ST_WAIT_CTS) || (state == ST_GUARD);
        tmr_val   = accept ? TMR_W'(CTS_TIMEOUT) : TMR_W'(GUARD_N);
    end

    cpt_payload_buf #(
        .DEPTH (MAX_BYTES),
        .IDX_W (IDX_W),
        .RD_W  (POS_W)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (load_we && !rts),
        .wr_idx  (load_idx),
        .wr_data (load_data),
        .rd_idx  (pos),
        .rd_data (buf_rd)
    );

    cpt_checksum u_chk (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .add     ((state == ST_SEND) && tx_ready && payload_phase),
        .din     (buf_rd),
        .chk_out (chk)
    );

    cpt_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tctl.load),
        .load_val (tmr_val),
        .run      (tctl.run),
        .expired  (tmr_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rts       <= 1'b0;
            pos       <= '0;
            len_q     <= '0;
            done      <= 1'b0;
            busy_nack <= 1'b0;
            cts_err   <= 1'b0;
        end else begin
            done      <= 1'b0;
            cts_err   <= 1'b0;
            busy_nack <= send_req && ((state != ST_IDLE) || !len_ok);
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        len_q <= POS_W'(send_len);
                        pos   <= '0;
                        rts   <= 1'b1;
                        state <= ST_WAIT_CTS;
                    end
                end
                ST_WAIT_CTS: begin
                    if (cts) begin
                        state <= ST_DRAIN;
                    end else if (tmr_exp) begin
                        rts     <= 1'b0;
                        cts_err <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_DRAIN: begin
                    if (tx_empty) state <= (pos > len_q) ? ST_GUARD : ST_SEND;
                end
                ST_SEND: begin
                    if (tx_ready) begin
                        pos   <= pos + POS_W'(1);
                        state <= ST_DRAIN;
                    end
                end
                ST_GUARD: begin
                    if (tmr_exp) begin
                        rts   <= 1'b0;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_valid = (state == ST_SEND);
    assign tx_data  = payload_phase ? buf_rd : chk;

    // R5: bytes only go out inside an rts window
    p_valid_needs_rts_r5: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> rts);
    // R6: offer starts only after the sink reported empty
    p_offer_after_empty_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(tx_empty));
    // R6: offered byte held until taken
    p_hold_offer_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R3: refusal follows a request
    p_nack_from_req_r3: assert property (@(posedge clk) disable iff (rst)
        busy_nack |-> $past(send_req));
    // R9: done marks the release of rts
    p_done_on_release_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rts && $past(rts)));
    p_done_err_apart_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && cts_err));
    // R10: timeout error leaves rts low
    p_err_releases_r10: assert property (@(posedge clk) disable iff (rst)
        cts_err |-> (!rts && $past(rts)));

endmodule

// File: tb/cmd_pkt_tx_tb.sv
module cmd_pkt_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB       = 8;
    localparam int HZ         = 20000;
    localparam int TMO        = 40;
    localparam int DRAIN      = 3;
    localparam int GUARD_N    = (HZ * 3 + 1999) / 2000;
    localparam int NVEC       = 5;

    // {len, byte0 .. byte7}
    localparam logic [67:0] VECS [0:NVEC-1] = '{
        {4'd3, 8'h83, 8'h43, 8'h2A, 40'h0},
        {4'd5, 8'h85, 8'h41, 8'h02, 8'h9C, 8'h02, 24'h0},
        {4'd1, 8'h7F, 56'h0},
        {4'd8, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80},
        {4'd2, 8'h12, 8'h34, 48'h0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_we = 1'b0;
    logic [2:0] load_idx = '0;
    logic [7:0] load_data = '0;
    logic       send_req = 1'b0;
    logic [3:0] send_len = '0;
    logic       busy_nack, rts, cts, tx_valid, tx_ready, tx_empty, done, cts_err;
    logic [7:0] tx_data;
    logic       cts_en = 1'b1;
    logic       mon_clr = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    cmd_pkt_tx #(.MAX_BYTES(MAXB), .CLK_HZ(HZ), .CTS_TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst(rst), .load_we(load_we), .load_idx(load_idx),
        .load_data(load_data), .send_req(send_req), .send_len(send_len),
        .busy_nack(busy_nack), .rts(rts), .cts(cts), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .tx_empty(tx_empty),
        .done(done), .cts_err(cts_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Byte sink: busy for DRAIN cycles after each accepted byte
    logic [3:0] sink_cnt;
    assign tx_empty = (sink_cnt == 0);
    assign tx_ready = tx_empty;
    always @(posedge clk) begin
        if (rst)                       sink_cnt <= '0;
        else if (tx_valid && tx_ready) sink_cnt <= 4'(DRAIN);
        else if (sink_cnt != 0)        sink_cnt <= sink_cnt - 4'd1;
    end

    // Far side answers rts with cts after three cycles
    logic [2:0] cts_sh;
    always @(posedge clk) begin
        if (rst) cts_sh <= '0;
        else     cts_sh <= {cts_sh[1:0], rts & cts_en};
    end
    assign cts = cts_sh[2];

    // Monitor, sampled on the falling edge
    logic [7:0] got [0:15];
    int  n_got, n_done, n_nack, n_err, early, acc_cyc, fall_cyc;
    logic cts_seen, rts_prev;
    always @(negedge clk) begin
        if (mon_clr) begin
            n_got = 0; n_done = 0; n_nack = 0; n_err = 0; early = 0;
            acc_cyc = 0; fall_cyc = 0; cts_seen = 1'b0;
        end else begin
            if (cts) cts_seen = 1'b1;
            if (tx_valid && !cts_seen) early++;
            if (tx_valid && tx_ready) begin
                if (n_got < 16) got[n_got] = tx_data;
                n_got++;
                acc_cyc = cyc + 1;
            end
            if (rts_prev && !rts) fall_cyc = cyc;
            if (done)      n_done++;
            if (busy_nack) n_nack++;
            if (cts_err)   n_err++;
        end
        rts_prev = rts;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        step();
        step();
        mon_clr = 1'b0;
    endtask

    task automatic load_byte(input int idx, input logic [7:0] b);
        load_we = 1'b1; load_idx = 3'(idx); load_data = b;
        step();
        load_we = 1'b0;
    endtask

    int req_cyc;
    task automatic request(input int len);
        send_req = 1'b1; send_len = 4'(len);
        req_cyc = cyc + 1;
        step();
        send_req = 1'b0;
    endtask

    task automatic wait_end(input string tag);
        int n = 0;
        while (n_done == 0 && n_err == 0 && n < 3000) begin
            step();
            n++;
        end
        chk(n < 3000, tag, n, 0);
        step();
    endtask

    function automatic logic [7:0] ref_chk(input logic [67:0] v);
        logic [7:0] x = 8'h00;
        for (int i = 0; i < int'(v[67:64]); i++) x ^= v[63-8*i -: 8];
        if (x[7]) x ^= 8'hC0;
        return x;
    endfunction

    task automatic check_packet(input logic [67:0] v, input string tag);
        int len = int'(v[67:64]);
        chk(n_got == len + 1, {tag, " R7 count"}, n_got, len + 1);
        for (int i = 0; i < len; i++)
            chk(got[i] == v[63-8*i -: 8], {tag, " R5 byte order"}, got[i], v[63-8*i -: 8]);
        chk(got[len] == ref_chk(v), {tag, " R7 checksum"}, got[len], ref_chk(v));
        chk(early == 0, {tag, " R5 no byte before cts"}, early, 0);
        chk(fall_cyc - acc_cyc == DRAIN + GUARD_N + 2, {tag, " R8 guard"},
            fall_cyc - acc_cyc, DRAIN + GUARD_N + 2);
        chk(n_done == 1, {tag, " R9 done pulse"}, n_done, 1);
        chk(rts == 1'b0, {tag, " R9 rts released"}, rts, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset state
        chk(!rts && !tx_valid && !done && !busy_nack && !cts_err, "R1 reset outputs",
            {rts, tx_valid, done, busy_nack, cts_err}, 0);

        // Table-driven packets: R2, R5, R7, R8, R9
        for (int v = 0; v < NVEC; v++) begin
            clear_mon();
            for (int i = 0; i < int'(VECS[v][67:64]); i++) load_byte(i, VECS[v][63-8*i -: 8]);
            request(int'(VECS[v][67:64]));
            chk(rts == 1'b1, "R2 rts after accept", rts, 1);
            wait_end("R2 packet end");
            check_packet(VECS[v], $sformatf("vec%0d", v));
            repeat (2) step();
        end

        // R3 busy refusal and R11 load ignored during transfer
        clear_mon();
        for (int i = 0; i < 5; i++) load_byte(i, VECS[1][63-8*i -: 8]);
        request(5);
        repeat (3) step();
        load_byte(4, 8'hEE);
        request(2);
        chk(busy_nack == 1'b1, "R3 nack pulse", busy_nack, 1);
        chk(rts == 1'b1, "R3 transfer continues", rts, 1);
        step();
        chk(busy_nack == 1'b0, "R3 nack one cycle", busy_nack, 0);
        wait_end("R3 packet end");
        check_packet(VECS[1], "busy R3 R11");
        chk(n_nack == 1, "R3 nack count", n_nack, 1);
        repeat (2) step();

        // R4 illegal lengths
        clear_mon();
        request(0);
        chk(busy_nack == 1'b1 && rts == 1'b0, "R4 zero length", {busy_nack, rts}, 2'b10);
        step();
        request(9);
        chk(busy_nack == 1'b1 && rts == 1'b0, "R4 over length", {busy_nack, rts}, 2'b10);
        repeat (3) step();
        chk(rts == 1'b0 && n_got == 0, "R4 nothing sent", n_got, 0);

        // R10 clear-to-send timeout
        cts_en = 1'b0;
        clear_mon();
        request(2);
        wait_end("R10 timeout end");
        chk(n_err == 1, "R10 error pulse", n_err, 1);
        chk(fall_cyc - req_cyc == TMO + 1, "R10 release time", fall_cyc - req_cyc, TMO + 1);
        chk(n_got == 0, "R10 no bytes", n_got, 0);
        chk(n_done == 0, "R10 no done", n_done, 0);
        chk(rts == 1'b0, "R10 rts low", rts, 0);
        cts_en = 1'b1;
        repeat (4) step();

        // R2 recovery after timeout
        clear_mon();
        for (int i = 0; i < 2; i++) load_byte(i, VECS[4][63-8*i -: 8]);
        request(2);
        wait_end("R2 after timeout");
        check_packet(VECS[4], "recover R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule